// File: doc/BRIEF.md
# Load/Store Address Translator

This block turns the virtual address of a load or store into a physical address and decides whether the access may proceed. It checks alignment first. It then picks the privilege mode that the access is judged under, rejects non-canonical addresses, and maps the direct-mapped kernel window without a lookup. For every other address it consults an external translation buffer and applies the per-mode read/write enables and the fault-on-read/fault-on-write bits of the returned entry. Accepted accesses then get a range check on the physical address and uncacheable-space handling.

Requests enter on a valid/ready port. The translation buffer is looked up combinationally in the same cycle: the block presents the page number and address-space number, and the buffer answers on the `tlb_*` inputs. Each result is held in one output register and offered on a valid/ready response port. A request is taken when `req_valid && req_ready`. `req_ready` is high whenever the response register is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response and `req_ready` are frozen. One-cycle event pulses, split by read and write, appear in the cycle the response register is loaded.

Top module: `lsxlate`

## Requirements
- R1: A request is accepted when `req_valid && req_ready`. Its response appears on the next cycle with `rsp_valid` high. While `rsp_valid && !rsp_ready`, `req_ready` is low and the response stays unchanged. After reset `rsp_valid` is low and `req_ready` is high.
- R2: `req_size` encodes 1/2/4/8 bytes as 0/1/2/3. If `req_va & (bytes-1)` is nonzero, the fault is ALIGN (code 1) ahead of every other check. The status word then holds only the write bit (bit 0), which is set for stores.
- R3: If `req_pc[0]` is 1, the effective mode is `alt_mode` when `req_altmode` is set and kernel (mode 0) otherwise. If `req_pc[0]` is 0, the effective mode is `cur_mode`. Modes are 0 kernel, 1 executive, 2 supervisor, 3 user.
- R4: On a virtual access, if bits 63:47 of the VA are not all equal, the fault is PAGE (code 2). The status is bad-VA (bit 4) plus violation (bit 1), plus write for stores.
- R5: If VA bits 47:41 equal 0x7E, the access uses the kernel window. If `cur_mode` is not kernel, the fault is VIOL (code 3) with status violation plus write for stores. Otherwise the PA is VA bits 39:0, with bits 43:40 all equal to VA bit 40 and bits above 43 zero.
- R6: On a translation-buffer miss, the status is miss (bit 5) plus write for stores. The fault is PTE_MISS (code 4) when `req_pte` is set and DATA_MISS (code 5) otherwise.
- R7: On a store that hits, a clear `tlb_wr_en[mode]` gives PAGE with status write+violation+fault-on-write (bit 3, if `tlb_fonw`). Otherwise a set `tlb_fonw` gives PAGE with status write+fault-on-write.
- R8: On a load that hits, a clear `tlb_rd_en[mode]` gives VIOL with status violation+fault-on-read (bit 2, if `tlb_fonr`). Otherwise a set `tlb_fonr` gives PAGE with status fault-on-read.
- R9: On a hit, the PA is `{tlb_ppn, va[12:0]}` with no offset truncation. With `req_phys` set, the PA is the VA unchanged and the validity and window checks are skipped. Any PA bit above 43 gives MCHK (code 6) with zero status. With no fault, the code and status are 0.
- R10: If PA bit 43 is set on a non-faulting access, `rsp_uncache` is 1 and PA bits 42:35 are cleared.
- R11: In the cycle after acceptance, the read or write events pulse for exactly one cycle. Access pulses for lookups. Hit pulses for physical, window or permitted lookups. Miss pulses for misses. Violation pulses for bad-VA, window-privilege and permission faults. Alignment faults raise no event.
- R12: `tlb_vpn` equals `req_va[63:13]` and `tlb_asn` equals `cur_asn`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken |
| req_va | input | 64 | Virtual address |
| req_size | input | 2 | log2 of access bytes |
| req_write | input | 1 | Store when 1 |
| req_phys | input | 1 | Address is already physical |
| req_altmode | input | 1 | Use alternate mode in privileged code |
| req_pte | input | 1 | Access fetches a page-table entry |
| req_pc | input | 64 | PC of the access; bit 0 marks privileged code |
| cur_mode | input | 2 | Current privilege mode |
| alt_mode | input | 2 | Alternate privilege mode |
| cur_asn | input | 8 | Address-space number |
| tlb_vpn | output | 51 | Lookup page number |
| tlb_asn | output | 8 | Lookup address-space number |
| tlb_hit | input | 1 | Lookup matched |
| tlb_ppn | input | 51 | Physical page number |
| tlb_rd_en | input | 4 | Read enable per mode |
| tlb_wr_en | input | 4 | Write enable per mode |
| tlb_fonr | input | 1 | Fault on read |
| tlb_fonw | input | 1 | Fault on write |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_pa | output | 64 | Physical address |
| rsp_uncache | output | 1 | Uncacheable access |
| rsp_fault | output | 3 | Fault code |
| rsp_status | output | 6 | Status flags |
| ev_rd_access | output | 1 | Read lookup event |
| ev_rd_hit | output | 1 | Read hit event |
| ev_rd_miss | output | 1 | Read miss event |
| ev_rd_acv | output | 1 | Read violation event |
| ev_wr_access | output | 1 | Write lookup event |
| ev_wr_hit | output | 1 | Write hit event |
| ev_wr_miss | output | 1 | Write miss event |
| ev_wr_acv | output | 1 | Write violation event |

## Verification
The only state is the response register and its valid bit. A corrupted valid bit shows at once: either `req_ready` drops with no response pending, or a held response changes while stalled. Both are visible on the cycle after the stall starts. Priority or mode-selection mistakes show on the very response that follows the offending request, as a wrong fault code or status bit. Stale event registers show as a pulse that lasts two cycles or that appears during a stall.

// File: rtl/lsxlate_pkg.sv
package lsxlate_pkg;
  localparam int VA_W       = 64;
  localparam int PAGE_SHIFT = 13;
  localparam int VPN_W      = VA_W - PAGE_SHIFT;
  localparam int IMPL_PA    = 44;
  localparam int VA_TOP     = 47;
  localparam int SX_BIT     = 40;
  localparam int UNC_LO     = 35;
  localparam int NMODE      = 4;

  localparam logic [1:0] MODE_KERNEL = 2'd0;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0, FLT_ALIGN = 3'd1, FLT_PAGE = 3'd2, FLT_VIOL = 3'd3,
    FLT_PTE_MISS = 3'd4, FLT_DATA_MISS = 3'd5, FLT_MCHK = 3'd6
  } fault_e;

  localparam int ST_WR    = 0;
  localparam int ST_ACV   = 1;
  localparam int ST_FONR  = 2;
  localparam int ST_FONW  = 3;
  localparam int ST_BADVA = 4;
  localparam int ST_MISS  = 5;
  localparam int ST_W     = 6;

  typedef struct packed {
    logic [VA_W-1:0] pa;
    logic            unc;
    fault_e          fault;
    logic [ST_W-1:0] status;
  } resp_t;

  typedef struct packed {
    logic acc, hit, miss, acv;
  } ev_t;
endpackage

// File: rtl/lsxlate_front.sv
module lsxlate_front
  import lsxlate_pkg::*;
(
  input  logic [VA_W-1:0] va,
  input  logic [1:0]      size_lg,
  input  logic            pc_priv,
  input  logic            altmode,
  input  logic [1:0]      cur_mode,
  input  logic [1:0]      alt_mode,
  output logic            misaligned,
  output logic            noncanon,
  output logic            in_window,
  output logic [1:0]      eff_mode,
  output logic [VA_W-1:0] window_pa
);
  localparam int HI_W = VA_W - VA_TOP;
  logic [3:0]      low_mask;
  logic [HI_W-1:0] hi_bits;

  always_comb begin
    low_mask   = (4'b0001 << size_lg) - 4'b0001;
    misaligned = |(va[2:0] & low_mask[2:0]);
    hi_bits    = va[VA_W-1:VA_TOP];
    noncanon   = !((&hi_bits) || !(|hi_bits));
    in_window  = (va[VA_TOP:41] == 7'h7E);
    eff_mode   = pc_priv ? (altmode ? alt_mode : MODE_KERNEL) : cur_mode;
    window_pa  = {{(VA_W-IMPL_PA){1'b0}}, {(IMPL_PA-SX_BIT){va[SX_BIT]}},
                  va[SX_BIT-1:0]};
  end
endmodule

// File: rtl/lsxlate_prot.sv
module lsxlate_prot
  import lsxlate_pkg::*;
(
  input  logic             write,
  input  logic [1:0]       mode,
  input  logic [NMODE-1:0] rd_en,
  input  logic [NMODE-1:0] wr_en,
  input  logic             fonr,
  input  logic             fonw,
  output logic             deny,
  output fault_e           kind,
  output logic [ST_W-1:0]  status
);
  always_comb begin
    deny   = 1'b0;
    kind   = FLT_NONE;
    status = '0;
    if (write) begin
      status[ST_WR] = 1'b1;
      if (!wr_en[mode]) begin
        deny = 1'b1; kind = FLT_PAGE;
        status[ST_ACV] = 1'b1; status[ST_FONW] = fonw;
      end else if (fonw) begin
        deny = 1'b1; kind = FLT_PAGE; status[ST_FONW] = 1'b1;
      end
    end else begin
      if (!rd_en[mode]) begin
        deny = 1'b1; kind = FLT_VIOL;
        status[ST_ACV] = 1'b1; status[ST_FONR] = fonr;
      end else if (fonr) begin
        deny = 1'b1; kind = FLT_PAGE; status[ST_FONR] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lsxlate_phys.sv
module lsxlate_phys
  import lsxlate_pkg::*;
(
  input  logic [VA_W-1:0] raw,
  output logic            out_of_range,
  output logic            unc,
  output logic [VA_W-1:0] pa
);
  localparam logic [VA_W-1:0] CLR_MASK =
    ((VA_W'(1) << (IMPL_PA-1)) - 1) & ~((VA_W'(1) << UNC_LO) - 1);
  always_comb begin
    out_of_range = |raw[VA_W-1:IMPL_PA];
    unc          = raw[IMPL_PA-1];
    pa           = unc ? (raw & ~CLR_MASK) : raw;
  end
endmodule

// File: rtl/lsxlate.sv
module lsxlate
  import lsxlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_va,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic              req_phys,
  input  logic              req_altmode,
  input  logic              req_pte,
  input  logic [63:0]       req_pc,
  input  logic [1:0]        cur_mode,
  input  logic [1:0]        alt_mode,
  input  logic [7:0]        cur_asn,
  output logic [50:0]       tlb_vpn,
  output logic [7:0]        tlb_asn,
  input  logic              tlb_hit,
  input  logic [50:0]       tlb_ppn,
  input  logic [3:0]        tlb_rd_en,
  input  logic [3:0]        tlb_wr_en,
  input  logic              tlb_fonr,
  input  logic              tlb_fonw,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [63:0]       rsp_pa,
  output logic              rsp_uncache,
  output logic [2:0]        rsp_fault,
  output logic [5:0]        rsp_status,
  output logic              ev_rd_access,
  output logic              ev_rd_hit,
  output logic              ev_rd_miss,
  output logic              ev_rd_acv,
  output logic              ev_wr_access,
  output logic              ev_wr_hit,
  output logic              ev_wr_miss,
  output logic              ev_wr_acv
);
  logic            misaligned, noncanon, in_window;
  logic [1:0]      eff_mode;
  logic [VA_W-1:0] window_pa, raw, phys_pa;
  logic            deny, oor, unc;
  fault_e          deny_kind;
  logic [ST_W-1:0] deny_st;
  logic            use_raw;
  resp_t           nxt, rsp_q;
  ev_t             ev, ev_rd_q, ev_wr_q;
  logic            accept;

  assign tlb_vpn = req_va[VA_W-1:PAGE_SHIFT];
  assign tlb_asn = cur_asn;

  lsxlate_front u_front (
    .va(req_va), .size_lg(req_size), .pc_priv(req_pc[0]),
    .altmode(req_altmode), .cur_mode(cur_mode), .alt_mode(alt_mode),
    .misaligned(misaligned), .noncanon(noncanon), .in_window(in_window),
    .eff_mode(eff_mode), .window_pa(window_pa)
  );

  lsxlate_prot u_prot (
    .write(req_write), .mode(eff_mode), .rd_en(tlb_rd_en),
    .wr_en(tlb_wr_en), .fonr(tlb_fonr), .fonw(tlb_fonw),
    .deny(deny), .kind(deny_kind), .status(deny_st)
  );

  lsxlate_phys u_phys (
    .raw(raw), .out_of_range(oor), .unc(unc), .pa(phys_pa)
  );

  // Fixed priority: alignment, validity, window privilege, miss,
  // permission, then physical range.
  always_comb begin
    nxt     = '{pa: '0, unc: 1'b0, fault: FLT_NONE, status: '0};
    ev      = '0;
    raw     = '0;
    use_raw = 1'b0;
    if (misaligned) begin
      nxt.fault = FLT_ALIGN;
      nxt.status[ST_WR] = req_write;
    end else if (req_phys) begin
      raw = req_va; use_raw = 1'b1; ev.hit = 1'b1;
    end else if (noncanon) begin
      nxt.fault = FLT_PAGE;
      nxt.status[ST_WR] = req_write;
      nxt.status[ST_ACV] = 1'b1;
      nxt.status[ST_BADVA] = 1'b1;
      ev.acv = 1'b1;
    end else if (in_window) begin
      if (cur_mode != MODE_KERNEL) begin
        nxt.fault = FLT_VIOL;
        nxt.status[ST_WR] = req_write;
        nxt.status[ST_ACV] = 1'b1;
        ev.acv = 1'b1;
      end else begin
        raw = window_pa; use_raw = 1'b1; ev.hit = 1'b1;
      end
    end else begin
      ev.acc = 1'b1;
      if (!tlb_hit) begin
        nxt.fault = req_pte ? FLT_PTE_MISS : FLT_DATA_MISS;
        nxt.status[ST_WR] = req_write;
        nxt.status[ST_MISS] = 1'b1;
        ev.miss = 1'b1;
      end else if (deny) begin
        nxt.fault = deny_kind;
        nxt.status = deny_st;
        ev.acv = 1'b1;
      end else begin
        raw = {tlb_ppn, req_va[PAGE_SHIFT-1:0]}; use_raw = 1'b1; ev.hit = 1'b1;
      end
    end
    if (use_raw) begin
      if (oor) nxt.fault = FLT_MCHK;
      else begin
        nxt.pa  = phys_pa;
        nxt.unc = unc;
      end
    end
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_q     <= '{pa: '0, unc: 1'b0, fault: FLT_NONE, status: '0};
      ev_rd_q   <= '0;
      ev_wr_q   <= '0;
    end else begin
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_q     <= nxt;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
      ev_rd_q <= (accept && !req_write) ? ev : '0;
      ev_wr_q <= (accept &&  req_write) ? ev : '0;
    end
  end

  assign rsp_pa       = rsp_q.pa;
  assign rsp_uncache  = rsp_q.unc;
  assign rsp_fault    = rsp_q.fault;
  assign rsp_status   = rsp_q.status;
  assign ev_rd_access = ev_rd_q.acc;
  assign ev_rd_hit    = ev_rd_q.hit;
  assign ev_rd_miss   = ev_rd_q.miss;
  assign ev_rd_acv    = ev_rd_q.acv;
  assign ev_wr_access = ev_wr_q.acc;
  assign ev_wr_hit    = ev_wr_q.hit;
  assign ev_wr_miss   = ev_wr_q.miss;
  assign ev_wr_acv    = ev_wr_q.acv;
endmodule

// File: rtl/lsxlate_chk.sv
module lsxlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [63:0] rsp_pa,
  input logic        rsp_uncache,
  input logic [2:0]  rsp_fault,
  input logic [5:0]  rsp_status,
  input logic        ev_rd_access, ev_rd_hit, ev_rd_miss, ev_rd_acv,
  input logic        ev_wr_access, ev_wr_hit, ev_wr_miss, ev_wr_acv
);
  logic any_rd, any_wr;
  assign any_rd = ev_rd_access | ev_rd_hit | ev_rd_miss | ev_rd_acv;
  assign any_wr = ev_wr_access | ev_wr_hit | ev_wr_miss | ev_wr_acv;

  // R1: a stalled response is held
  a_r1_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) &&
    $stable(rsp_fault) && $stable(rsp_status) && $stable(rsp_uncache));

  // R2: alignment fault carries at most the write bit
  a_r2_align_status: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == 3'd1 |-> rsp_status[5:1] == 5'd0);

  // R6: miss faults carry the miss bit
  a_r6_miss_status: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_fault == 3'd4 || rsp_fault == 3'd5) |-> rsp_status[5]);

  // R9: a clean access has an in-range address and empty status
  a_r9_clean_range: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == 3'd0 |-> rsp_pa[63:44] == 20'd0 &&
    rsp_status == 6'd0);

  // R10: uncacheable results have bits 42:35 cleared
  a_r10_unc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_uncache |-> rsp_pa[42:35] == 8'd0 && rsp_pa[43]);

  // R11: events are exclusive by direction, hit/miss exclusive, one-cycle
  a_r11_dir_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(any_rd && any_wr));
  a_r11_kind_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_rd_hit, ev_rd_miss, ev_rd_acv, ev_wr_hit, ev_wr_miss, ev_wr_acv}));
  a_r11_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (any_rd || any_wr) |-> rsp_valid);
  a_r11_no_pulse_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> !(any_rd || any_wr));
endmodule

bind lsxlate lsxlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_uncache(rsp_uncache),
  .rsp_fault(rsp_fault), .rsp_status(rsp_status),
  .ev_rd_access(ev_rd_access), .ev_rd_hit(ev_rd_hit), .ev_rd_miss(ev_rd_miss),
  .ev_rd_acv(ev_rd_acv), .ev_wr_access(ev_wr_access), .ev_wr_hit(ev_wr_hit),
  .ev_wr_miss(ev_wr_miss), .ev_wr_acv(ev_wr_acv)
);

// File: tb/lsxlate_test.sv
module lsxlate_test;
  typedef struct packed {
    logic        phys, alt, pte, priv, wr;
    logic [1:0]  cur, altm, sz;
    logic [63:0] va;
    logic        hit;
    logic [50:0] ppn;
    logic [3:0]  rd, wen;
    logic        fonr, fonw;
    logic [2:0]  efault;
    logic [5:0]  est;
    logic [63:0] epa;
    logic        eunc;
    logic [7:0]  eev;   // {rd acc,hit,miss,acv, wr acc,hit,miss,acv}
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    // R9: load hit, PA = ppn:offset
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0,2'd2, 64'h0000_0000_1234_5678, 1'b1,51'h55,4'b0001,4'b0001,1'b0,1'b0, 3'd0,6'h00,64'h0000_0000_000A_B678,1'b0, 8'hC0},
    // R2: misaligned 4-byte store
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 2'd0,2'd0,2'd2, 64'h0000_0000_1234_5679, 1'b1,51'h55,4'b1111,4'b1111,1'b0,1'b0, 3'd1,6'h01,64'h0,1'b0, 8'h00},
    // R2: misaligned 8-byte load
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0,2'd3, 64'h0000_0000_1234_5674, 1'b1,51'h55,4'b1111,4'b1111,1'b0,1'b0, 3'd1,6'h00,64'h0,1'b0, 8'h00},
    // R4: non-canonical store
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 2'd0,2'd0,2'd0, 64'h0001_0000_0000_0000, 1'b1,51'h55,4'b1111,4'b1111,1'b0,1'b0, 3'd2,6'h13,64'h0,1'b0, 8'h01},
    // R5: window access in user mode
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 2'd3,2'd0,2'd0, 64'hFFFF_FC00_0000_1000, 1'b1,51'h55,4'b1111,4'b1111,1'b0,1'b0, 3'd3,6'h02,64'h0,1'b0, 8'h10},
    // R5: window kernel, bit 40 clear
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0,2'd0, 64'hFFFF_FC00_0000_2000, 1'b0,51'h0,4'b0000,4'b0000,1'b0,1'b0, 3'd0,6'h00,64'h0000_0000_0000_2000,1'b0, 8'h40},
    // R5 R10: window kernel, bit 40 set, uncacheable
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0,2'd0, 64'hFFFF_FD00_0000_2000, 1'b0,51'h0,4'b0000,4'b0000,1'b0,1'b0, 3'd0,6'h00,64'h0000_0800_0000_2000,1'b1, 8'h40},
    // R6: normal miss on load
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0,2'd2, 64'h0000_0000_1234_5678, 1'b0,51'h0,4'b0000,4'b0000,1'b0,1'b0, 3'd5,6'h20,64'h0,1'b0, 8'hA0},
    // R6: table-access miss on store
    '{1'b0,1'b0,1'b1,1'b0,1'b1, 2'd0,2'd0,2'd3, 64'h0000_0000_1234_5678, 1'b0,51'h0,4'b0000,4'b0000,1'b0,1'b0, 3'd4,6'h21,64'h0,1'b0, 8'h0A},
    // R7: store, user write disabled, fonw set
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 2'd3,2'd0,2'd0, 64'h0000_0000_1234_5678, 1'b1,51'h55,4'b1111,4'b0001,1'b0,1'b1, 3'd2,6'h0B,64'h0,1'b0, 8'h09},
    // R7: store permitted but fonw set
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 2'd3,2'd0,2'd0, 64'h0000_0000_1234_5678, 1'b1,51'h55,4'b1111,4'b1000,1'b0,1'b1, 3'd2,6'h09,64'h0,1'b0, 8'h09},
    // R8: load, read disabled, fonr set
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 2'd3,2'd0,2'd0, 64'h0000_0000_1234_5678, 1'b1,51'h55,4'b0001,4'b1111,1'b1,1'b0, 3'd3,6'h06,64'h0,1'b0, 8'h90},
    // R8: load permitted but fonr set
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 2'd3,2'd0,2'd0, 64'h0000_0000_1234_5678, 1'b1,51'h55,4'b1000,4'b1111,1'b1,1'b0, 3'd2,6'h04,64'h0,1'b0, 8'h90},
    // R3: privileged PC with alt flag, alt mode user
    '{1'b0,1'b1,1'b0,1'b1,1'b0, 2'd0,2'd3,2'd0, 64'h0000_0000_1234_5678, 1'b1,51'h55,4'b0001,4'b1111,1'b0,1'b0, 3'd3,6'h02,64'h0,1'b0, 8'h90},
    // R3: privileged PC without alt flag => kernel
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 2'd3,2'd3,2'd0, 64'h0000_0000_1234_5678, 1'b1,51'h55,4'b0001,4'b1111,1'b0,1'b0, 3'd0,6'h00,64'h0000_0000_000A_B678,1'b0, 8'hC0},
    // R9: PA out of range => machine check
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0,2'd0, 64'h0000_0000_1234_5678, 1'b1,51'h8000_0000,4'b0001,4'b1111,1'b0,1'b0, 3'd6,6'h00,64'h0,1'b0, 8'hC0},
    // R9 R10: physical, uncacheable
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 2'd3,2'd0,2'd0, 64'h0000_0FF0_0000_0040, 1'b0,51'h0,4'b0000,4'b0000,1'b0,1'b0, 3'd0,6'h00,64'h0000_0800_0000_0040,1'b1, 8'h40},
    // R9: physical out of range
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0,2'd0, 64'h0000_1000_0000_0000, 1'b0,51'h0,4'b0000,4'b0000,1'b0,1'b0, 3'd6,6'h00,64'h0,1'b0, 8'h40},
    // R2: misaligned beats non-canonical
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0,2'd1, 64'h0001_0000_0000_0001, 1'b1,51'h55,4'b1111,4'b1111,1'b0,1'b0, 3'd1,6'h00,64'h0,1'b0, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_phys = 1'b0;
  logic req_altmode = 1'b0, req_pte = 1'b0, rsp_ready = 1'b1;
  logic [63:0] req_va = '0, req_pc = '0;
  logic [1:0]  req_size = '0, cur_mode = '0, alt_mode = '0;
  logic [7:0]  cur_asn = 8'h3C;
  logic        tlb_hit = 1'b0, tlb_fonr = 1'b0, tlb_fonw = 1'b0;
  logic [50:0] tlb_ppn = '0;
  logic [3:0]  tlb_rd_en = '0, tlb_wr_en = '0;
  logic        req_ready, rsp_valid, rsp_uncache;
  logic [50:0] tlb_vpn;
  logic [7:0]  tlb_asn;
  logic [63:0] rsp_pa;
  logic [2:0]  rsp_fault;
  logic [5:0]  rsp_status;
  logic ev_rd_access, ev_rd_hit, ev_rd_miss, ev_rd_acv;
  logic ev_wr_access, ev_wr_hit, ev_wr_miss, ev_wr_acv;
  int   n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  lsxlate uut (.*);

  function automatic logic [7:0] evs();
    return {ev_rd_access, ev_rd_hit, ev_rd_miss, ev_rd_acv,
            ev_wr_access, ev_wr_hit, ev_wr_miss, ev_wr_acv};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_phys = v.phys; req_altmode = v.alt; req_pte = v.pte;
    req_pc = {63'h40, v.priv}; req_write = v.wr;
    cur_mode = v.cur; alt_mode = v.altm; req_size = v.sz; req_va = v.va;
    tlb_hit = v.hit; tlb_ppn = v.ppn; tlb_rd_en = v.rd; tlb_wr_en = v.wen;
    tlb_fonr = v.fonr; tlb_fonw = v.fonw;
  endtask

  task automatic check_vec(input int i, input vec_t v);
    string t;
    t = $sformatf("vec%0d", i);
    chk({t, " R1 valid"}, 64'(rsp_valid), 64'd1);
    chk({t, " R2-R9 fault"}, 64'(rsp_fault), 64'(v.efault));
    chk({t, " status"}, 64'(rsp_status), 64'(v.est));
    chk({t, " R11 events"}, 64'(evs()), 64'(v.eev));
    if (v.efault == 3'd0) begin
      chk({t, " R9 pa"}, rsp_pa, v.epa);
      chk({t, " R10 uncache"}, 64'(rsp_uncache), 64'(v.eunc));
    end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 reset req_ready", 64'(req_ready), 64'd1);
    chk("R11 reset events", 64'(evs()), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check_vec(i, VECS[i]);
    end

    // R12: lookup key outputs
    req_va = 64'hFFFF_0000_ABCD_E000;
    #1;
    chk("R12 vpn", 64'(tlb_vpn), 64'(req_va[63:13]));
    chk("R12 asn", 64'(tlb_asn), 64'h3C);

    // R1 R11: back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    drive(VECS[0]); req_valid = 1'b1;
    @(negedge clk);
    chk("R1 stall first valid", 64'(rsp_valid), 64'd1);
    chk("R1 stall ready low", 64'(req_ready), 64'd0);
    chk("R11 first pulse", 64'(evs()), 64'hC0);
    drive(VECS[4]);
    @(negedge clk);
    chk("R1 held pa", rsp_pa, 64'h0000_0000_000A_B678);
    chk("R1 held fault", 64'(rsp_fault), 64'd0);
    chk("R11 no pulse in stall", 64'(evs()), 64'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 second taken", 64'(rsp_fault), 64'd3);
    chk("R11 second pulse", 64'(evs()), 64'h10);
    @(negedge clk);
    chk("R1 drained", 64'(rsp_valid), 64'd0);
    chk("R11 pulse one cycle", 64'(evs()), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule